// File: doc/BRIEF.md
# Multi-Issue Window Dependency Checker

This block is the issue stage of a multi-issue pipeline. It holds a window of up to `W` decoded instructions, each naming one destination and two source registers. Every cycle it tests the occupied slots, oldest first, against older slots in the window and against a pending-write scoreboard for instructions already in flight. It issues the longest run of hazard-free instructions counted from the oldest one. Issue is strictly in program order: the first blocked slot stops everything behind it.

Instructions arrive one per cycle on a ready/valid stream. Writebacks arrive on their own port and clear pending bits. A configuration input selects the refill policy, and a three-state machine carries it out. In `FILL` the window loads instructions and issues nothing. Once all `W` slots are loaded it moves to `DRAIN`. In `DRAIN` it issues and accepts nothing until the window is empty, then returns to `FILL`. In `GLIDE` it issues and accepts in the same cycle, and a slot freed by issue is offered to the stream from the next cycle on.

The transitions are as follows. `FILL`→`GLIDE` and `DRAIN`→`GLIDE` happen whenever gliding is selected. `FILL`→`DRAIN` happens when the window becomes full. `DRAIN`→`FILL` happens when the window becomes empty. `GLIDE`→`DRAIN` or `GLIDE`→`FILL` happens when fixed mode is selected, depending on whether entries remain.

Top module: `isu_issue_window`

## Requirements
- R1: After reset the window is empty, no slot issues (`iss_mask` is 0), `in_ready` is 1 and no register is pending.
- R2: `iss_mask` is always a contiguous run of ones starting at bit 0 (bit 0 is the oldest entry). Once an entry is blocked, no younger entry issues in that cycle, even if it is independent.
- R3: An entry whose nonzero source register has its pending bit set does not issue (read-after-write on an instruction in flight).
- R4: An entry does not issue while an older entry still in the window writes one of its sources (read-after-write), writes its destination (write-after-write), or reads its destination (write-after-read).
- R5: An entry whose nonzero destination has its pending bit set does not issue (write-after-write on an instruction in flight).
- R6: Register 0 takes part in no dependency: it is never pending and never matches another entry.
- R7: Issuing an entry with a nonzero destination sets that register's pending bit from the next cycle. A writeback clears the bit. A writeback in the same cycle as the check lets a dependent entry issue in that cycle.
- R8: In fixed mode the window loads one instruction per cycle and issues nothing until all `W` slots hold instructions. After that, `in_ready` stays 0 until every entry has issued.
- R9: In gliding mode `in_ready` is 1 whenever fewer than `W` entries are held. Ready entries issue every cycle. An accepted instruction is placed behind the remaining entries, so program order is kept.
- R10: For every issued slot `k`, `iss_dst[k]`, `iss_src_a[k]` and `iss_src_b[k]` carry the fields of the `k`-th oldest entry. Non-issued slots read 0.
- R11: Switching from gliding to fixed mode with entries left drains those entries before a new group is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_glide | input | 1 | 1 selects gliding refill, 0 selects fixed-group refill |
| in_valid | input | 1 | Incoming instruction is valid |
| in_ready | output | 1 | Window can take an instruction this cycle |
| in_dst | input | RW | Destination register of incoming instruction |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| wb_valid | input | 1 | A writeback completes this cycle |
| wb_reg | input | RW | Register written back |
| iss_mask | output | W | Per-slot issue, bit 0 = oldest |
| iss_dst | output | W×RW | Destination of each issued slot |
| iss_src_a | output | W×RW | First source of each issued slot |
| iss_src_b | output | W×RW | Second source of each issued slot |

## Verification
A group of independent instructions in fixed mode shows whether the window drains in one cycle and keeps the stream closed meanwhile. A group whose oldest entry waits on an in-flight register, with independent entries behind it, tells strict in-order stopping apart from skipping ahead. Groups with write-after-write and write-after-read pairs, and a group using only register 0, separate true, false and absent dependencies. A writeback that lands in the blocking cycle separates same-cycle bypass from a one-cycle delay. Long pseudo-random streams in gliding mode, with mode switches in between, exercise refill placement, mode changes while entries remain, and the scoreboard under mixed traffic.

// File: rtl/isu_pkg.sv
package isu_pkg;
    typedef enum logic [1:0] {
        S_FILL  = 2'd0,
        S_DRAIN = 2'd1,
        S_GLIDE = 2'd2
    } win_state_e;
endpackage

// File: rtl/isu_hazard.sv
module isu_hazard #(
    parameter int W    = 4,
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG),
    parameter int CW   = $clog2(W + 1)
) (
    input  logic                  en,
    input  logic [W-1:0]          occ,
    input  logic [W-1:0][RW-1:0]  ent_dst,
    input  logic [W-1:0][RW-1:0]  ent_sa,
    input  logic [W-1:0][RW-1:0]  ent_sb,
    input  logic [NREG-1:0]       pend,
    input  logic                  wb_valid,
    input  logic [RW-1:0]         wb_reg,
    output logic [W-1:0]          go,
    output logic [CW-1:0]         go_cnt
);
    logic [NREG-1:0] eff;
    logic [W-1:0]    blk;

    // writeback in the same cycle lifts the pending bit for this check
    always_comb begin
        eff = pend;
        if (wb_valid) eff[wb_reg] = 1'b0;
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            blk[i] = 1'b0;
            if (ent_sa[i] != '0 && eff[ent_sa[i]])   blk[i] = 1'b1;
            if (ent_sb[i] != '0 && eff[ent_sb[i]])   blk[i] = 1'b1;
            if (ent_dst[i] != '0 && eff[ent_dst[i]]) blk[i] = 1'b1;
            for (int j = 0; j < W; j++) begin
                if (j < i) begin
                    if (ent_dst[j] != '0 &&
                        (ent_sa[i] == ent_dst[j] || ent_sb[i] == ent_dst[j] ||
                         ent_dst[i] == ent_dst[j]))
                        blk[i] = 1'b1;
                    if (ent_dst[i] != '0 &&
                        (ent_dst[i] == ent_sa[j] || ent_dst[i] == ent_sb[j]))
                        blk[i] = 1'b1;
                end
            end
        end
    end

    // in-order prefix: the chain breaks at the first blocked or empty slot
    always_comb begin
        go[0] = en & occ[0] & ~blk[0];
        for (int i = 1; i < W; i++)
            go[i] = go[i-1] & occ[i] & ~blk[i];
        go_cnt = '0;
        for (int i = 0; i < W; i++)
            go_cnt = go_cnt + CW'(go[i]);
    end
endmodule

// File: rtl/isu_scoreboard.sv
module isu_scoreboard #(
    parameter int W    = 4,
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          go,
    input  logic [W-1:0][RW-1:0]  ent_dst,
    input  logic                  wb_valid,
    input  logic [RW-1:0]         wb_reg,
    output logic [NREG-1:0]       pend
);
    logic [NREG-1:0] set_vec;
    logic [NREG-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < W; i++)
            if (go[i] && ent_dst[i] != '0) set_vec[ent_dst[i]] = 1'b1;
        if (wb_valid) clr_vec[wb_reg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    p_reg0_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0]);

    p_set_on_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));

    p_clear_on_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !set_vec[wb_reg]) |=> !pend[$past(wb_reg)]);
endmodule

// File: rtl/isu_window.sv
module isu_window
    import isu_pkg::*;
#(
    parameter int W  = 4,
    parameter int RW = 4,
    parameter int CW = $clog2(W + 1),
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_glide,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [RW-1:0]         in_dst,
    input  logic [RW-1:0]         in_sa,
    input  logic [RW-1:0]         in_sb,
    input  logic [W-1:0]          go,
    input  logic [CW-1:0]         go_cnt,
    output logic                  issue_en,
    output logic [W-1:0]          occ,
    output logic [W-1:0][RW-1:0]  e_dst,
    output logic [W-1:0][RW-1:0]  e_sa,
    output logic [W-1:0][RW-1:0]  e_sb
);
    win_state_e state, state_n;
    logic [CW-1:0] cnt, cnt_after, cnt_n;
    logic accept;
    logic [W-1:0][RW-1:0] n_dst, n_sa, n_sb;

    // output process: stream readiness and issue permission per state
    always_comb begin
        in_ready = 1'b0;
        issue_en = 1'b0;
        unique case (state)
            S_FILL:  in_ready = 1'b1;
            S_DRAIN: issue_en = 1'b1;
            S_GLIDE: begin
                issue_en = 1'b1;
                in_ready = (cnt < CW'(W));
            end
            default: ;
        endcase
    end

    assign accept    = in_valid & in_ready;
    assign cnt_after = cnt - go_cnt;
    assign cnt_n     = cnt_after + CW'(accept);

    always_comb begin
        for (int k = 0; k < W; k++) occ[k] = (k < int'(cnt));
    end

    // next-state process
    always_comb begin
        state_n = state;
        unique case (state)
            S_FILL:  if (cfg_glide)              state_n = S_GLIDE;
                     else if (cnt_n == CW'(W))   state_n = S_DRAIN;
            S_DRAIN: if (cfg_glide)              state_n = S_GLIDE;
                     else if (cnt_n == '0)       state_n = S_FILL;
            S_GLIDE: if (!cfg_glide)             state_n = (cnt_n == '0) ? S_FILL : S_DRAIN;
            default:                             state_n = S_FILL;
        endcase
    end

    // shift out issued entries, append the accepted one behind the rest
    always_comb begin
        n_dst = e_dst;
        n_sa  = e_sa;
        n_sb  = e_sb;
        for (int k = 0; k < W; k++) begin
            int sidx;
            sidx = k + int'(go_cnt);
            if (sidx < W && sidx < int'(cnt)) begin
                n_dst[k] = e_dst[sidx[IW-1:0]];
                n_sa[k]  = e_sa[sidx[IW-1:0]];
                n_sb[k]  = e_sb[sidx[IW-1:0]];
            end else if (accept && k == int'(cnt_after)) begin
                n_dst[k] = in_dst;
                n_sa[k]  = in_sa;
                n_sb[k]  = in_sb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FILL;
            cnt   <= '0;
            e_dst <= '0;
            e_sa  <= '0;
            e_sb  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            e_dst <= n_dst;
            e_sa  <= n_sa;
            e_sb  <= n_sb;
        end
    end

    p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go & (go + W'(1))) == '0);

    p_fill_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |-> (go == '0));

    p_drain_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |-> !in_ready);

    p_glide_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GLIDE && cnt < CW'(W)) |-> in_ready);

    p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CW'(W)) && (go_cnt <= cnt));

    p_drain_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |-> (cnt != '0));
endmodule

// File: rtl/isu_issue_window.sv
module isu_issue_window #(
    parameter int W    = 4,
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_glide,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [RW-1:0]         in_dst,
    input  logic [RW-1:0]         in_src_a,
    input  logic [RW-1:0]         in_src_b,
    input  logic                  wb_valid,
    input  logic [RW-1:0]         wb_reg,
    output logic [W-1:0]          iss_mask,
    output logic [W-1:0][RW-1:0]  iss_dst,
    output logic [W-1:0][RW-1:0]  iss_src_a,
    output logic [W-1:0][RW-1:0]  iss_src_b
);
    localparam int CW = $clog2(W + 1);

    logic                 issue_en;
    logic [W-1:0]         occ, go;
    logic [CW-1:0]        go_cnt;
    logic [W-1:0][RW-1:0] e_dst, e_sa, e_sb;
    logic [NREG-1:0]      pend;

    isu_window #(.W(W), .RW(RW)) u_win (
        .clk(clk), .rst_n(rst_n), .cfg_glide(cfg_glide),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_sa(in_src_a), .in_sb(in_src_b),
        .go(go), .go_cnt(go_cnt), .issue_en(issue_en), .occ(occ),
        .e_dst(e_dst), .e_sa(e_sa), .e_sb(e_sb)
    );

    isu_hazard #(.W(W), .NREG(NREG), .RW(RW)) u_haz (
        .en(issue_en), .occ(occ),
        .ent_dst(e_dst), .ent_sa(e_sa), .ent_sb(e_sb),
        .pend(pend), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .go(go), .go_cnt(go_cnt)
    );

    isu_scoreboard #(.W(W), .NREG(NREG), .RW(RW)) u_sb (
        .clk(clk), .rst_n(rst_n), .go(go), .ent_dst(e_dst),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .pend(pend)
    );

    always_comb begin
        iss_mask = go;
        for (int k = 0; k < W; k++) begin
            iss_dst[k]   = go[k] ? e_dst[k] : '0;
            iss_src_a[k] = go[k] ? e_sa[k]  : '0;
            iss_src_b[k] = go[k] ? e_sb[k]  : '0;
        end
    end
endmodule

// File: tb/isu_issue_window_bench.sv
module isu_issue_window_bench;
    localparam int W    = 4;
    localparam int NREG = 16;
    localparam int RW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_glide = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic wb_valid = 1'b0;
    logic [RW-1:0] wb_reg = '0;
    logic [W-1:0] iss_mask;
    logic [W-1:0][RW-1:0] iss_dst, iss_src_a, iss_src_b;

    always #5 clk = ~clk;

    isu_issue_window #(.W(W), .NREG(NREG), .RW(RW)) u_isu_issue_window (
        .clk(clk), .rst_n(rst_n), .cfg_glide(cfg_glide),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .iss_mask(iss_mask), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b)
    );

    typedef struct { int d; int a; int b; } ent_t;
    ent_t q[$];
    bit   pend[NREG];
    int   mst;          // 0 loading, 1 draining, 2 gliding
    int   nchk = 0;
    int   nfail = 0;
    int   seed = 12345;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 32'h7fff) % m;
    endfunction

    task automatic step(input bit g, input bit v, input int d, input int a, input int b,
                        input bit wv, input int wr, input string tag);
        bit epend[NREG];
        bit exp_rdy;
        int n;
        int exp_mask;
        ent_t e;
        @(negedge clk);
        cfg_glide = g; in_valid = v;
        in_dst = RW'(d); in_src_a = RW'(a); in_src_b = RW'(b);
        wb_valid = wv; wb_reg = RW'(wr);
        #1;
        exp_rdy = (mst == 0) || (mst == 2 && q.size() < W);
        for (int r = 0; r < NREG; r++) epend[r] = pend[r] && !(wv && wr == r);
        n = 0;
        if (mst != 0) begin
            for (int i = 0; i < q.size(); i++) begin
                bit blk;
                blk = 0;
                if (q[i].a != 0 && epend[q[i].a]) blk = 1;
                if (q[i].b != 0 && epend[q[i].b]) blk = 1;
                if (q[i].d != 0 && epend[q[i].d]) blk = 1;
                for (int j = 0; j < i; j++) begin
                    if (q[j].d != 0 && (q[i].a == q[j].d || q[i].b == q[j].d || q[i].d == q[j].d)) blk = 1;
                    if (q[i].d != 0 && (q[i].d == q[j].a || q[i].d == q[j].b)) blk = 1;
                end
                if (blk) break;
                n++;
            end
        end
        exp_mask = (1 << n) - 1;
        chk(in_ready == exp_rdy, {tag, " ready"}, int'(in_ready), int'(exp_rdy));
        chk(int'(iss_mask) == exp_mask, {tag, " mask"}, int'(iss_mask), exp_mask);
        for (int k = 0; k < n; k++) begin
            // R10: fields of issued slots in program order
            chk(int'(iss_dst[k]) == q[k].d && int'(iss_src_a[k]) == q[k].a &&
                int'(iss_src_b[k]) == q[k].b, "R10 fields",
                int'(iss_dst[k]), q[k].d);
        end
        // model update for the coming edge
        if (wv) pend[wr] = 0;
        for (int k = 0; k < n; k++) if (q[k].d != 0) pend[q[k].d] = 1;
        for (int k = 0; k < n; k++) void'(q.pop_front());
        if (v && exp_rdy) begin
            e.d = d; e.a = a; e.b = b;
            q.push_back(e);
        end
        case (mst)
            0: if (g) mst = 2; else if (q.size() == W) mst = 1;
            1: if (g) mst = 2; else if (q.size() == 0) mst = 0;
            default: if (!g) mst = (q.size() == 0) ? 0 : 1;
        endcase
    endtask

    task automatic rand_phase(input bit g, input int cycles, input string tag);
        for (int c = 0; c < cycles; c++)
            step(g, rnd(4) != 0, rnd(8), rnd(8), rnd(8), rnd(2) == 1, rnd(8), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", nchk, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) pend[r] = 0;
        mst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // fixed group of independent instructions
        step(0, 1, 1, 2, 3, 0, 0, "R8");
        step(0, 1, 4, 5, 6, 0, 0, "R8");
        step(0, 1, 7, 8, 9, 0, 0, "R8");
        step(0, 1, 10, 11, 12, 0, 0, "R8");
        step(0, 1, 13, 14, 15, 0, 0, "R8");
        // oldest waits on in-flight r1, independent ones behind it
        step(0, 1, 2, 1, 0, 0, 0, "R2");
        step(0, 1, 3, 0, 0, 0, 0, "R2");
        step(0, 1, 5, 0, 0, 0, 0, "R2");
        step(0, 1, 6, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 1, 1, "R7");
        // write-after-write in flight, then in-window conflicts
        step(0, 1, 4, 0, 0, 0, 0, "R5");
        step(0, 1, 8, 9, 9, 0, 0, "R5");
        step(0, 1, 9, 8, 0, 0, 0, "R4");
        step(0, 1, 11, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 4, "R4");
        step(0, 0, 0, 0, 0, 1, 8, "R4");
        step(0, 0, 0, 0, 0, 0, 0, "R4");
        // register zero only
        step(0, 1, 0, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 0, "R6");
        for (int r = 1; r < NREG; r++) step(0, 0, 0, 0, 0, 1, r, "R7");
        rand_phase(1, 400, "R9");
        rand_phase(0, 200, "R11");
        rand_phase(1, 100, "R9");
        rand_phase(0, 100, "R8");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule